// File: doc/BRIEF.md
# PS/2 Port Host Register Front End

This block is the software-facing side of a PS/2 keyboard or mouse port. A processor reaches it through a small word-addressed register window. Through that window it can set interrupt enables, read port status, move bytes to and from the attached device, keep a clock divisor value and read a fixed set of identification bytes. The serial line protocol and the device itself sit outside the block.

The receive side is a byte stream. The device side offers a byte with `rx_valid`/`rx_data`. The block accepts it (`rx_ready` high for one cycle) only when software reads the data register while a byte is offered. `rx_valid` doubles as the "byte pending" flag, so the source must hold `rx_valid` and `rx_data` steady until it sees `rx_ready`. The transmit side is a one-entry valid/ready stream. A data-register write loads the byte and raises `tx_valid`, and `tx_valid` stays high until the sink accepts with `tx_ready`. A new write while a byte is still waiting replaces that byte. Back-pressure from the sink is never shown in status, because transmit-empty always reads as set. The interrupt output is a level, computed combinationally from the control register and `rx_valid`.

Top module: `ps2h_host`

## Requirements
- R1: After reset, control, clock divisor and the held byte are zero, and `irq`, `bus_rvalid`, `tx_valid` and `rx_ready` are low.
- R2: A read request (`bus_req`=1, `bus_we`=0) yields `bus_rvalid`=1 with `bus_rdata` in the following cycle. A write yields `bus_rvalid`=0.
- R3: Control (byte offset 0x000, low 8 bits) and clock divisor (offset 0x00C, low 8 bits) read back the last value written. Wider write bits are dropped, and the other read bits are zero.
- R4: Status (offset 0x004) reads bit 6 = 1 and bit 4 = `rx_valid`. Bit 2 is the XOR of the eight bits of the held byte. All other bits read 0.
- R5: A data read (offset 0x008) while `rx_valid`=1 raises `rx_ready` for exactly that request cycle. It returns `rx_data` and stores that byte as the held byte.
- R6: A data read while `rx_valid`=0 leaves `rx_ready` low and returns the held byte unchanged.
- R7: A data write places `bus_wdata[7:0]` on `tx_data` with `tx_valid`=1 from the next cycle. `tx_valid` holds until a cycle with `tx_ready`=1, and a further write while it is held replaces the byte.
- R8: `irq` = (`rx_valid` AND control bit 4) OR control bit 3. It follows a change of `rx_valid` in the same cycle.
- R9: Interrupt status (offset 0x010) reads bit 1 = 1 and bit 0 = `rx_valid`, with the other bits 0.
- R10: Byte offsets 0xFE0, 0xFE4, … 0xFFC read the identification bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R11: Reads of any other offset return zero. Writes to status, interrupt status, identification or unmapped offsets change neither control, divisor nor `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| rx_valid | input | 1 | Device byte offered / pending |
| rx_data | input | 8 | Offered byte |
| rx_ready | output | 1 | Byte accepted this cycle |
| tx_valid | output | 1 | Byte waiting for the device |
| tx_data | output | 8 | Byte for the device |
| tx_ready | input | 1 | Device accepts the waiting byte |
| irq | output | 1 | Level interrupt |

## Verification
Two events can land in the same cycle: a data-register read that pops the offered byte, and the drop of the pending flag that the receive interrupt depends on. The bench sweeps all 256 byte values through the pop path with the receive interrupt enabled. For each byte it first reads status while the byte is still pending, so the parity bit must still reflect the previous byte and not the offered one. It then pops the byte and removes it, and it judges that `irq` falls in the same cycle `rx_valid` does. A second overlap is a transmit write landing on an accept cycle. The bench checks that the new byte survives with `tx_valid` still high.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_DATA = 2;
  localparam int unsigned IDX_DIV  = 3;
  localparam int unsigned IDX_ISR  = 4;

  localparam int unsigned STAT_TXE = 6;
  localparam int unsigned STAT_RXF = 4;
  localparam int unsigned STAT_PAR = 2;

  localparam int unsigned CR_TXIE  = 3;
  localparam int unsigned CR_RXIE  = 4;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    logic [7:0] b;
    case (i)
      3'd0: b = 8'h50;
      3'd1: b = 8'h10;
      3'd2: b = 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/ps2h_ctrl_regs.sv
module ps2h_ctrl_regs #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_div,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DIV_W-1:0]  div
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      div  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= wdata[CTRL_W-1:0];
      if (wr_div)  div  <= wdata[DIV_W-1:0];
    end
  end

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> $stable(div));
  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl));
endmodule

// File: rtl/ps2h_rx_hold.sv
module ps2h_rx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_data_req,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic [7:0] last,
  output logic       parity
);
  assign rx_ready = rd_data_req & rx_valid;
  assign parity   = ^last;

  always_ff @(posedge clk) begin
    if (!rst_n)        last <= '0;
    else if (rx_ready) last <= rx_data;
  end

  // R5
  pop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> last == $past(rx_data));
  // R6
  no_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |=> $stable(last));
  // R5
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid);
endmodule

// File: rtl/ps2h_tx_slot.sv
module ps2h_tx_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (wr_data) begin
      tx_valid <= 1'b1;
      tx_data  <= wdata[7:0];
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_data) |=> (tx_valid && $stable(tx_data)));
  // R7
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (tx_valid && tx_data == $past(wdata[7:0])));
endmodule

// File: rtl/ps2h_host.sv
module ps2h_host #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  import ps2h_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              is_id;
  logic              rd, wr;
  logic              wr_ctrl, wr_div, wr_data, rd_data;
  logic [CTRL_W-1:0] ctrl;
  logic [DIV_W-1:0]  div;
  logic [7:0]        last;
  logic              parity;
  logic [DATA_W-1:0] rd_next;

  assign idx   = bus_addr[ADDR_W-1:2];
  assign is_id = &bus_addr[ADDR_W-1:5];
  assign rd    = bus_req & ~bus_we;
  assign wr    = bus_req &  bus_we;

  assign wr_ctrl = wr & ~is_id & (idx == IDX_W'(IDX_CTRL));
  assign wr_div  = wr & ~is_id & (idx == IDX_W'(IDX_DIV));
  assign wr_data = wr & ~is_id & (idx == IDX_W'(IDX_DATA));
  assign rd_data = rd & ~is_id & (idx == IDX_W'(IDX_DATA));

  ps2h_ctrl_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_div(wr_div),
    .wdata(bus_wdata), .ctrl(ctrl), .div(div)
  );

  ps2h_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .rd_data_req(rd_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .last(last), .parity(parity)
  );

  ps2h_tx_slot #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(bus_wdata),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign irq = (rx_valid & ctrl[CR_RXIE]) | ctrl[CR_TXIE];

  always_comb begin
    rd_next = '0;
    if (is_id) begin
      rd_next[7:0] = id_byte(bus_addr[4:2]);
    end else begin
      case (idx)
        IDX_W'(IDX_CTRL): rd_next[CTRL_W-1:0] = ctrl;
        IDX_W'(IDX_STAT): begin
          rd_next[STAT_TXE] = 1'b1;
          rd_next[STAT_RXF] = rx_valid;
          rd_next[STAT_PAR] = parity;
        end
        IDX_W'(IDX_DATA): rd_next[7:0] = rx_ready ? rx_data : last;
        IDX_W'(IDX_DIV):  rd_next[DIV_W-1:0] = div;
        IDX_W'(IDX_ISR):  rd_next[1:0] = {1'b1, rx_valid};
        default:          rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_next;
    end
  end

  // R2
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
  // R2
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid);
  // R8
  txie_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && bus_wdata[CR_TXIE] |=> irq);
endmodule

// File: tb/test_ps2h_host.sv
module test_ps2h_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ps2h_host i_ps2h_host (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic par8(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return (n % 2) == 1;
  endfunction

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic popped);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 popped = rx_ready;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
    check("R2 rvalid after read", {31'd0, bus_rvalid}, 32'd1);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic p;
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 tx_valid", {31'd0, tx_valid}, 0);
    check("R1 rvalid", {31'd0, bus_rvalid}, 0);
    check("R1 rx_ready", {31'd0, rx_ready}, 0);
    rd(12'h000, d, p); check("R1 ctrl", d, 0);
    rd(12'h00C, d, p); check("R1 div", d, 0);
    rd(12'h008, d, p); check("R1 last", d, 0);

    // R3 readback sweep
    for (int v = 0; v < 512; v += 37) begin
      wr(12'h00C, 32'(v) | 32'hABC0_0000);
      rd(12'h00C, d, p); check("R3 div readback", d, 32'(v & 8'hFF));
    end
    wr(12'h000, 32'h1E7);
    rd(12'h000, d, p); check("R3 ctrl readback", d, 32'hE7);
    wr(12'h000, 0);
    // R2 write gives no rvalid
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = 12'h00C; bus_wdata = 32'h33;
    @(negedge clk); bus_req = 0; bus_we = 0;
    check("R2 no rvalid on write", {31'd0, bus_rvalid}, 0);

    // R4 R5 R6 R8 sweep of all bytes with receive interrupt enabled
    wr(12'h000, 32'h10);
    prev = 8'h00;
    for (int b = 0; b < 256; b++) begin
      @(negedge clk); rx_data = 8'(b); rx_valid = 1;
      #1 check("R8 irq pending", {31'd0, irq}, 1);
      rd(12'h004, d, p);
      check("R4 status pending", d, 32'h50 | (32'(par8(prev)) << 2));
      check("R5 no pop on status", {31'd0, p}, 0);
      rd(12'h008, d, p);
      check("R5 pop strobe", {31'd0, p}, 1);
      check("R5 popped byte", d, 32'(b));
      rx_valid = 0;
      #1 check("R8 irq falls with pending", {31'd0, irq}, 0);
      prev = 8'(b);
      rd(12'h004, d, p);
      check("R4 status idle", d, 32'h40 | (32'(par8(prev)) << 2));
      if (b % 16 == 5) begin
        rd(12'h008, d, p);
        check("R6 no pop", {31'd0, p}, 0);
        check("R6 held byte", d, 32'(b));
      end
    end

    // R8 R9 interrupt combinations
    for (int c = 0; c < 4; c++) begin
      for (int pe = 0; pe < 2; pe++) begin
        wr(12'h000, 32'(c) << 3);
        @(negedge clk); rx_valid = pe[0]; rx_data = 8'h77;
        #1 check("R8 irq level", {31'd0, irq}, 32'((pe[0] & c[1]) | c[0]));
        rd(12'h010, d, p);
        check("R9 int status", d, 32'h2 | 32'(pe));
        @(negedge clk); rx_valid = 0;
      end
    end
    wr(12'h000, 0);

    // R7 transmit
    wr(12'h008, 32'h1A5);
    check("R7 tx valid", {31'd0, tx_valid}, 1);
    check("R7 tx byte", {24'd0, tx_data}, 32'hA5);
    repeat (3) @(negedge clk);
    check("R7 tx held", {23'd0, tx_valid, tx_data}, 32'h1A5);
    wr(12'h008, 32'h3C);
    check("R7 tx replaced", {23'd0, tx_valid, tx_data}, 32'h13C);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    check("R7 tx accepted", {31'd0, tx_valid}, 0);
    // R7 write on an accept cycle keeps new byte
    wr(12'h008, 32'h11);
    @(negedge clk); tx_ready = 1; bus_req = 1; bus_we = 1; bus_addr = 12'h008; bus_wdata = 32'h22;
    @(negedge clk); tx_ready = 0; bus_req = 0; bus_we = 0;
    check("R7 write during accept", {23'd0, tx_valid, tx_data}, 32'h122);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;

    // R10 identification
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h50; 1: e = 8'h10; 2: e = 8'h04; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      rd(12'hFE0 + 12'(i * 4), d, p); check("R10 id byte", d, 32'(e));
    end

    // R11 unmapped reads and ignored writes
    wr(12'h000, 32'h05); wr(12'h00C, 32'h9A);
    rd(12'h014, d, p); check("R11 unmapped 014", d, 0);
    rd(12'h800, d, p); check("R11 unmapped 800", d, 0);
    rd(12'hFDC, d, p); check("R11 unmapped FDC", d, 0);
    wr(12'h004, 32'hFF); wr(12'h010, 32'hFF); wr(12'hFE0, 32'hFF);
    wr(12'hFE8, 32'hFF); wr(12'h100, 32'hFF);
    rd(12'h000, d, p); check("R11 ctrl kept", d, 32'h05);
    rd(12'h00C, d, p); check("R11 div kept", d, 32'h9A);
    check("R11 no tx", {31'd0, tx_valid}, 0);
    rd(12'hFE8, d, p); check("R11 id unchanged", d, 32'h04);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule